// File: doc/BRIEF.md
# Sleep-Mode Sequencer for an 8-bit Microcontroller

This block decides when the clocks of a small 8-bit controller run. Software writes a two-bit mode request. Bit 0 asks for idle and bit 1 asks for power-down. In idle, only the CPU clock enable drops. Internal RAM, the timers, the serial port and the interrupt logic stay on the peripheral clock enable. In power-down, the block drops all three enables, including the oscillator enable, and the chip is frozen.

The two modes end in different ways. Idle ends on any enabled interrupt request, or as soon as the synchronised reset pin is seen high. In the second case the CPU runs again before the internal reset has been qualified. During that short window the block raises an inhibit on internal RAM accesses, while port accesses stay allowed. Power-down ignores interrupts. The reset pin clears the oscillator-off state asynchronously. The CPU and peripheral clocks then stay gated for a parameterised stabilisation count before the block returns to the running state.

The reset pin is synchronised and qualified. An internal reset is produced only after a run of consecutive high samples equal to two machine cycles of twelve clocks. That internal reset stays asserted while the pin stays high.

Top module: `pm_sequencer`

## Requirements
- R1: After the block's own reset, cpuClkEn, periphClkEn and oscEn are 1, while ramInhibit, coreReset and modeState (2'b00) are 0.
- R2: A mode write of 2'b01 (bit 0 = idle) while running leaves modeState at 2'b01 after the next clock edge. In that state cpuClkEn is 0 and periphClkEn and oscEn stay 1.
- R3: In idle, a high irqPending returns the block to running on the next edge, with cpuClkEn at 1 and modeState cleared to 2'b00.
- R4: A mode write with bit 1 set (bit 1 = power-down) drops all three enables on the next edge. Power-down wins over idle when both bits are written, and modeState then reads 2'b11.
- R5: In power-down, irqPending has no effect. A high rstPin raises oscEn at once, without waiting for a clock edge.
- R6: After a power-down wake, cpuClkEn and periphClkEn stay 0 until the (STAB_CNT+2)-th clock edge after rstPin rises, and turn 1 on that edge.
- R7: coreReset rises on the 26th edge after rstPin goes high, which is 24 consecutive synchronised high samples. A pulse that gives only 23 samples never raises coreReset, and coreReset falls after rstPin goes low.
- R8: When rstPin rises during idle, cpuClkEn returns on the third edge with ramInhibit at 1. ramInhibit stays at 1 through the edge on which coreReset rises and clears on the edge after it.
- R9: coreReset clears modeState. Mode writes are ignored outside the running state and while a reset is pending.
- R10: irqPending has no effect while the block is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous, active-low reset of the block itself |
| rstPin | input | 1 | Raw external reset pin, asynchronous, active high |
| modeWrEn | input | 1 | Software write strobe for the mode request |
| modeWrData | input | 2 | Mode request: bit 0 idle, bit 1 power-down |
| irqPending | input | 1 | Any enabled interrupt request |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Enable for the RAM, timer, serial port and interrupt clocks |
| oscEn | output | 1 | Master oscillator enable |
| ramInhibit | output | 1 | Blocks internal RAM accesses in the idle-to-reset window |
| coreReset | output | 1 | Qualified, held internal reset |
| modeState | output | 2 | Current mode request bits |

## Verification
The assertions take for granted that mode writes come only while the CPU clock runs and no reset is pending, because the block drops any other write. They also take for granted that rstPin changes only between clock edges, apart from its asynchronous effect on the oscillator enable. The stimulus drives every input on the falling clock edge and raises rstPin only on a falling edge. It keeps rstPin high long enough for a wake or a qualified reset to complete before the next mode test, so every window in the checks starts from the running state.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_STAB  = 2'd3
  } pmState_t;

  typedef struct packed {
    logic captureMode;
    logic clearMode;
    logic enterPd;
    logic loadStab;
    logic stabTick;
    logic setInhibit;
  } pmStrobe_t;
endpackage

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int QUAL_CNT = 24,
  parameter int STAB_CNT = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rstPin,
  input  pmStrobe_t strb,
  input  logic [1:0] modeWrData,
  output logic      rstSync,
  output logic      coreReset,
  output logic      oscOff,
  output logic      stabDone,
  output logic      ramInhibit,
  output logic [1:0] modeReg
);
  localparam int QW = $clog2(QUAL_CNT + 1);
  localparam int SW = $clog2(STAB_CNT + 1);
  localparam logic [QW-1:0] QUAL_TOP = QW'(QUAL_CNT);
  localparam logic [SW-1:0] STAB_TOP = SW'(STAB_CNT);

  logic          rstMeta;
  logic [QW-1:0] qualCnt;
  logic [SW-1:0] stabCnt;

  // two-flop synchroniser for the raw pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstMeta <= 1'b0;
      rstSync <= 1'b0;
    end else begin
      rstMeta <= rstPin;
      rstSync <= rstMeta;
    end
  end

  // run-length qualifier, counts only while the oscillator runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) qualCnt <= '0;
    else if (!rstSync) qualCnt <= '0;
    else if (!oscOff && qualCnt != QUAL_TOP) qualCnt <= qualCnt + 1'b1;
  end
  assign coreReset = (qualCnt == QUAL_TOP);

  // oscillator-off flag, cleared asynchronously by the pin
  always_ff @(posedge clk or negedge rstN or posedge rstPin) begin
    if (!rstN) oscOff <= 1'b0;
    else if (rstPin) oscOff <= 1'b0;
    else if (strb.enterPd) oscOff <= 1'b1;
  end

  // stabilisation down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stabCnt <= '0;
    else if (strb.loadStab) stabCnt <= STAB_TOP;
    else if (strb.stabTick && stabCnt != '0) stabCnt <= stabCnt - 1'b1;
  end
  assign stabDone = (stabCnt == '0);

  // RAM inhibit window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ramInhibit <= 1'b0;
    else if (strb.setInhibit) ramInhibit <= 1'b1;
    else if (coreReset || !rstSync) ramInhibit <= 1'b0;
  end

  // mode request register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeReg <= 2'b00;
    else if (coreReset || strb.clearMode) modeReg <= 2'b00;
    else if (strb.captureMode) modeReg <= modeWrData;
  end

  // R7
  qual_needs_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |-> $past(rstSync));

  // R6
  stab_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStab |=> !stabDone);
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [1:0] modeWrData,
  input  logic       irqPending,
  input  logic       rstSync,
  input  logic       coreReset,
  input  logic       oscOff,
  input  logic       stabDone,
  output pmStrobe_t  strb,
  output logic       cpuClkEn,
  output logic       periphClkEn
);
  pmState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PM_RUN;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    unique case (state)
      PM_RUN: begin
        if (modeWrEn && !coreReset && !rstSync) begin
          strb.captureMode = 1'b1;
          if (modeWrData[1]) begin
            nextState    = PM_PDOWN;
            strb.enterPd = 1'b1;
          end else if (modeWrData[0]) begin
            nextState = PM_IDLE;
          end
        end
      end
      PM_IDLE: begin
        if (rstSync) begin
          nextState       = PM_RUN;
          strb.clearMode  = 1'b1;
          strb.setInhibit = 1'b1;
        end else if (irqPending) begin
          nextState      = PM_RUN;
          strb.clearMode = 1'b1;
        end
      end
      PM_PDOWN: begin
        if (!oscOff) begin
          nextState      = PM_STAB;
          strb.loadStab  = 1'b1;
          strb.clearMode = 1'b1;
        end
      end
      PM_STAB: begin
        strb.stabTick = 1'b1;
        if (stabDone) nextState = PM_RUN;
      end
      default: nextState = PM_RUN;
    endcase
  end

  assign cpuClkEn    = (state == PM_RUN);
  assign periphClkEn = (state == PM_RUN) || (state == PM_IDLE);

  // R5
  pd_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_PDOWN && oscOff) |=> (state == PM_PDOWN));

  // R6
  stab_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_STAB && !stabDone) |=> !cpuClkEn);

  // R3
  idle_irq_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PM_IDLE && irqPending) |=> cpuClkEn);
endmodule

// File: rtl/pm_sequencer.sv
module pm_sequencer
  import pm_pkg::*;
#(
  parameter int CYC_PER_MC = 12,
  parameter int RST_MC     = 2,
  parameter int STAB_CNT   = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rstPin,
  input  logic       modeWrEn,
  input  logic [1:0] modeWrData,
  input  logic       irqPending,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       oscEn,
  output logic       ramInhibit,
  output logic       coreReset,
  output logic [1:0] modeState
);
  localparam int QUAL_CNT = CYC_PER_MC * RST_MC;

  pmStrobe_t strb;
  logic rstSync, oscOff, stabDone;

  pm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .irqPending(irqPending), .rstSync(rstSync), .coreReset(coreReset),
    .oscOff(oscOff), .stabDone(stabDone), .strb(strb),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn)
  );

  pm_datapath #(.QUAL_CNT(QUAL_CNT), .STAB_CNT(STAB_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .rstPin(rstPin), .strb(strb),
    .modeWrData(modeWrData), .rstSync(rstSync), .coreReset(coreReset),
    .oscOff(oscOff), .stabDone(stabDone), .ramInhibit(ramInhibit),
    .modeReg(modeState)
  );

  assign oscEn = !oscOff;

  // R8
  inhibit_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramInhibit |-> cpuClkEn);

  // R9
  reset_clears_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |=> (modeState == 2'b00));
endmodule

// File: tb/tb_pm_sequencer.sv
module tb_pm_sequencer;
  localparam int STAB = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rstPin = 1'b0;
  logic modeWrEn = 1'b0;
  logic [1:0] modeWrData = 2'b00;
  logic irqPending = 1'b0;
  logic cpuClkEn, periphClkEn, oscEn, ramInhibit, coreReset;
  logic [1:0] modeState;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pm_sequencer #(.STAB_CNT(STAB)) dut (
    .clk(clk), .rstN(rstN), .rstPin(rstPin), .modeWrEn(modeWrEn),
    .modeWrData(modeWrData), .irqPending(irqPending), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .ramInhibit(ramInhibit),
    .coreReset(coreReset), .modeState(modeState)
  );

  // {wrEn, wrData[1:0], irq, expCpu, expPer, expOsc, expMode[1:0]}
  localparam logic [8:0] VEC [9] = '{
    9'b0_00_0_111_00,  // R1 running, nothing applied
    9'b1_01_0_011_01,  // R2 enter idle
    9'b0_00_0_011_01,  // R2 idle holds
    9'b1_10_0_011_01,  // R9 write ignored in idle
    9'b0_00_1_111_00,  // R3 irq ends idle
    9'b0_00_1_111_00,  // R10 irq while running
    9'b1_00_0_111_00,  // R2 zero write stays running
    9'b1_01_0_011_01,  // R2 idle again
    9'b0_00_1_111_00   // R3 irq ends idle
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic seen;
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 cpuClkEn", cpuClkEn, 1);
    chk("R1 periphClkEn", periphClkEn, 1);
    chk("R1 oscEn", oscEn, 1);
    chk("R1 ramInhibit", ramInhibit, 0);
    chk("R1 coreReset", coreReset, 0);
    chk("R1 modeState", modeState, 0);

    for (int i = 0; i < 9; i++) begin
      modeWrEn   = VEC[i][8];
      modeWrData = VEC[i][7:6];
      irqPending = VEC[i][5];
      step(1);
      chk("R2/R3/R10 vec cpu", cpuClkEn, VEC[i][4]);
      chk("R2/R3/R10 vec periph", periphClkEn, VEC[i][3]);
      chk("R2/R3/R10 vec osc", oscEn, VEC[i][2]);
      chk("R2/R3/R9 vec mode", modeState, VEC[i][1:0]);
    end
    modeWrEn = 1'b0; modeWrData = 2'b00; irqPending = 1'b0;
    step(2);

    // R7 short pulse: 23 samples, no reset
    seen = 1'b0;
    rstPin = 1'b1;
    for (int i = 0; i < 23; i++) begin step(1); seen |= coreReset; end
    rstPin = 1'b0;
    for (int i = 0; i < 6; i++) begin step(1); seen |= coreReset; end
    chk("R7 short pulse", seen, 0);

    // R7 exact pulse: 24 samples qualify
    seen = 1'b0;
    rstPin = 1'b1;
    for (int i = 0; i < 24; i++) begin step(1); seen |= coreReset; end
    rstPin = 1'b0;
    for (int i = 0; i < 6; i++) begin step(1); seen |= coreReset; end
    chk("R7 exact pulse", seen, 1);
    chk("R7 released", coreReset, 0);

    // R7 exact timing and R9 write during pending reset
    rstPin = 1'b1;
    step(5);
    modeWrEn = 1'b1; modeWrData = 2'b01;
    step(1);
    modeWrEn = 1'b0; modeWrData = 2'b00;
    chk("R9 write while reset pending", modeState, 0);
    chk("R9 cpu still running", cpuClkEn, 1);
    step(19);
    chk("R7 before 26th edge", coreReset, 0);
    step(1);
    chk("R7 on 26th edge", coreReset, 1);
    rstPin = 1'b0;
    step(4);
    chk("R7 falls after pin low", coreReset, 0);

    // R8 idle exit by reset
    modeWrEn = 1'b1; modeWrData = 2'b01;
    step(1);
    modeWrEn = 1'b0; modeWrData = 2'b00;
    chk("R2 idle entered", cpuClkEn, 0);
    rstPin = 1'b1;
    step(2);
    chk("R8 cpu gated 2 edges", cpuClkEn, 0);
    step(1);
    chk("R8 cpu back 3rd edge", cpuClkEn, 1);
    chk("R8 inhibit raised", ramInhibit, 1);
    chk("R8 mode cleared", modeState, 0);
    step(23);
    chk("R8 coreReset at 26", coreReset, 1);
    chk("R8 inhibit through reset edge", ramInhibit, 1);
    step(1);
    chk("R8 inhibit cleared", ramInhibit, 0);
    rstPin = 1'b0;
    step(4);

    // R4 power-down priority
    modeWrEn = 1'b1; modeWrData = 2'b11;
    step(1);
    modeWrEn = 1'b0; modeWrData = 2'b00;
    chk("R4 osc off", oscEn, 0);
    chk("R4 cpu off", cpuClkEn, 0);
    chk("R4 periph off", periphClkEn, 0);
    chk("R4 mode both", modeState, 2'b11);
    irqPending = 1'b1;
    step(5);
    irqPending = 1'b0;
    chk("R5 irq ignored osc", oscEn, 0);
    chk("R5 irq ignored mode", modeState, 2'b11);
    chk("R5 irq ignored cpu", cpuClkEn, 0);
    step(2);

    // R5/R6 asynchronous wake and stabilisation
    rstPin = 1'b1;
    #1;
    chk("R5 async osc on", oscEn, 1);
    step(STAB + 1);
    chk("R6 cpu gated", cpuClkEn, 0);
    chk("R6 periph gated", periphClkEn, 0);
    chk("R6 mode cleared on wake", modeState, 0);
    step(1);
    chk("R6 cpu resumes", cpuClkEn, 1);
    chk("R6 periph resumes", periphClkEn, 1);
    step(26 - (STAB + 2));
    chk("R7 reset after wake", coreReset, 1);
    rstPin = 1'b0;
    step(4);
    chk("R9 mode after wake", modeState, 0);
    chk("R7 reset released after wake", coreReset, 0);

    finish_run();
  end
endmodule